// File: doc/BRIEF.md
# Configuration DMA Command Queue

This block collects transfer commands for a configuration data mover from a simple register-write port and hands them, one at a time, to a read engine. Software builds each command by writing a source address, a destination address and a source length (in 32-bit words). A write to the destination-length slot turns the staged values into one queue entry. Software watches the full flag and keeps issuing commands until it sees the queue full.

The engine side pops the oldest entry and presents it as an address, a word count, a last marker and a write-back enable, with a valid/ready handshake. It then waits for the read engine to report that the transfer has finished. Every finished command produces a one-cycle DMA-done pulse. Bit 0 of the source address flags a command as the last of a sequence. For that command the block then waits for the downstream configuration port to report idle and produces a second, combined done pulse. Commands with a misaligned source address, and commands written while the queue is full, are discarded and produce an error pulse.

Top module: `cfg_dma_cmdq`

## Requirements
- R1: After synchronous reset, q_empty is 1, q_full is 0, and cmd_valid, dma_done, port_done and cmd_err are all 0.
- R2: A write with wr_sel=3 (destination length) queues one command built from the most recent writes with wr_sel=0 (source address), wr_sel=1 (destination address) and wr_sel=2 (source length). Commands are presented in the order they were queued.
- R3: cmd_addr equals the staged source address with bit 0 cleared. cmd_words equals the low LEN_W bits of the staged source length, taken as a count of 32-bit words.
- R4: cmd_last equals bit 0 of the staged source address.
- R5: cmd_wb is 0 when the staged destination address is all ones, and 1 otherwise.
- R6: q_full is 1 when DEPTH (default 4) commands are stored and q_empty is 1 when none are stored. Each flag reflects the count as of the last clock edge.
- R7: A queueing write made while q_full is 1 is dropped and raises cmd_err for one cycle. The commands already stored are kept unchanged.
- R8: A queueing write whose staged source address has bits [2:1] not both zero raises cmd_err for one cycle and stores nothing.
- R9: While cmd_valid is 1 and cmd_ready is 0, cmd_valid and all command fields stay stable. After a command is accepted, no further command is presented until xfer_done has been seen for it.
- R10: Each xfer_done seen after a command was accepted produces exactly one one-cycle dma_done pulse, in the next cycle.
- R11: port_done pulses only for a command with cmd_last=1. It comes one cycle after port_idle is sampled high at a clock edge later than the one that took xfer_done, and so never in the same cycle as dma_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register slot: 0 src addr, 1 dst addr, 2 src len, 3 dst len (queues) |
| wr_data | input | ADDR_W | Write data |
| q_full | output | 1 | Queue holds DEPTH commands |
| q_empty | output | 1 | Queue holds no commands |
| cmd_err | output | 1 | One-cycle pulse: command discarded |
| cmd_valid | output | 1 | Command presented to read engine |
| cmd_ready | input | 1 | Read engine accepts the command |
| cmd_addr | output | ADDR_W | Source address, 64-bit aligned |
| cmd_words | output | LEN_W | Transfer length in 32-bit words |
| cmd_last | output | 1 | Last command of a sequence |
| cmd_wb | output | 1 | Destination write-back enabled |
| xfer_done | input | 1 | Read engine finished the accepted command |
| port_idle | input | 1 | Downstream configuration port has drained |
| dma_done | output | 1 | One-cycle pulse per finished command |
| port_done | output | 1 | One-cycle pulse when the last command has drained |

## Verification
The main path is driven with a non-last command without write-back, a command with a real destination, and a last-flagged command. These separate the clearing of the last bit from the address, the decoding of the write-back sentinel, and the extra drain wait. For the last command, port_idle is held low for several cycles and then raised. A second last command runs with port_idle already high. Together they show that the combined done waits for the drain and never shares a cycle with dma_done. A full queue is built while the engine is stalled, so the overflow error can be told apart from a lost entry, and the stored commands are then read back in order. A misaligned address shows that a rejected command leaves the queue empty.

// File: rtl/cfgq_pkg.sv
package cfgq_pkg;
  typedef enum logic [1:0] {
    SEL_SRC_ADDR = 2'd0,
    SEL_DST_ADDR = 2'd1,
    SEL_SRC_LEN  = 2'd2,
    SEL_DST_LEN  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ISSUE,
    ENG_BUSY,
    ENG_DRAIN
  } eng_state_e;
endpackage

// File: rtl/cfgq_stage.sv
module cfgq_stage
  import cfgq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 27,
  parameter int ALIGN_BITS = 3,
  localparam int ENTRY_W   = ADDR_W + LEN_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic               fifo_full,
  output logic               push,
  output logic [ENTRY_W-1:0] push_data,
  output logic               err_pulse
);
  logic [ADDR_W-1:0] src_addr_q;
  logic [ADDR_W-1:0] dst_addr_q;
  logic [LEN_W-1:0]  src_len_q;
  logic              misaligned;
  logic              commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr_q <= '0;
      dst_addr_q <= '1;
      src_len_q  <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_SRC_ADDR: src_addr_q <= wr_data;
        SEL_DST_ADDR: dst_addr_q <= wr_data;
        SEL_SRC_LEN:  src_len_q  <= wr_data[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (ALIGN_BITS > 1) begin : g_align
      assign misaligned = |src_addr_q[ALIGN_BITS-1:1];
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate

  assign commit = wr_en && (reg_sel_e'(wr_sel) == SEL_DST_LEN);
  assign push   = commit && !misaligned && !fifo_full;

  // entry layout: {wb, last, words, addr}
  assign push_data = {(dst_addr_q != {ADDR_W{1'b1}}), src_addr_q[0], src_len_q,
                      src_addr_q[ADDR_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= commit && (misaligned || fifo_full);
  end
endmodule

// File: rtl/cfgq_fifo.sv
module cfgq_fifo #(
  parameter int W     = 61,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nx;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];

  always_comb begin
    count_nx = count;
    if (do_push && !do_pop)      count_nx = count + 1'b1;
    else if (do_pop && !do_push) count_nx = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count_nx;
      full  <= (count_nx == CW'(DEPTH));
      empty <= (count_nx == '0);
    end
  end
endmodule

// File: rtl/cfgq_engine.sv
module cfgq_engine
  import cfgq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 27,
  localparam int ENTRY_W = ADDR_W + LEN_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRY_W-1:0] entry,
  input  logic               fifo_empty,
  output logic               pop,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [LEN_W-1:0]   cmd_words,
  output logic               cmd_last,
  output logic               cmd_wb,
  input  logic               xfer_done,
  input  logic               port_idle,
  output logic               dma_done,
  output logic               port_done
);
  eng_state_e state;

  assign pop = (state == ENG_IDLE) && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_words <= '0;
      cmd_last  <= 1'b0;
      cmd_wb    <= 1'b0;
      dma_done  <= 1'b0;
      port_done <= 1'b0;
    end else begin
      dma_done  <= 1'b0;
      port_done <= 1'b0;
      case (state)
        ENG_IDLE: if (!fifo_empty) begin
          cmd_addr  <= entry[ADDR_W-1:0];
          cmd_words <= entry[ADDR_W +: LEN_W];
          cmd_last  <= entry[ADDR_W+LEN_W];
          cmd_wb    <= entry[ADDR_W+LEN_W+1];
          cmd_valid <= 1'b1;
          state     <= ENG_ISSUE;
        end
        ENG_ISSUE: if (cmd_ready) begin
          cmd_valid <= 1'b0;
          state     <= ENG_BUSY;
        end
        ENG_BUSY: if (xfer_done) begin
          dma_done <= 1'b1;
          state    <= cmd_last ? ENG_DRAIN : ENG_IDLE;
        end
        ENG_DRAIN: if (port_idle) begin
          port_done <= 1'b1;
          state     <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_cmdq.sv
module cfg_dma_cmdq #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 27,
  parameter int DEPTH      = 4,
  parameter int ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              q_full,
  output logic              q_empty,
  output logic              cmd_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_words,
  output logic              cmd_last,
  output logic              cmd_wb,
  input  logic              xfer_done,
  input  logic              port_idle,
  output logic              dma_done,
  output logic              port_done
);
  localparam int ENTRY_W = ADDR_W + LEN_W + 2;

  logic               push, pop;
  logic [ENTRY_W-1:0] push_data, head;

  cfgq_stage #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS)) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fifo_full(q_full), .push(push), .push_data(push_data), .err_pulse(cmd_err)
  );

  cfgq_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(push_data), .pop(pop),
    .dout(head), .full(q_full), .empty(q_empty)
  );

  cfgq_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst(rst), .entry(head), .fifo_empty(q_empty), .pop(pop),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_words(cmd_words), .cmd_last(cmd_last), .cmd_wb(cmd_wb),
    .xfer_done(xfer_done), .port_idle(port_idle),
    .dma_done(dma_done), .port_done(port_done)
  );
endmodule

// File: rtl/cfg_dma_cmdq_checker.sv
module cfg_dma_cmdq_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 27
) (
  input logic              clk,
  input logic              rst,
  input logic              q_full,
  input logic              q_empty,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_words,
  input logic              cmd_last,
  input logic              cmd_wb,
  input logic              dma_done,
  input logic              port_done
);
  // R6: the two occupancy flags exclude each other
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(q_full && q_empty));

  // R9: a stalled command holds steady
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
      $stable(cmd_words) && $stable(cmd_last) && $stable(cmd_wb)));

  // R9: an accepted command is not followed at once by another
  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  // R3: presented address never carries the last flag
  a_r3_addr_bit0_clear: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !cmd_addr[0]);

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    dma_done |=> !dma_done);

  // R11: combined done never coincides with command done and is a pulse
  a_r11_port_done_apart: assert property (@(posedge clk) disable iff (rst)
    port_done |-> !dma_done);

  a_r11_port_done_single: assert property (@(posedge clk) disable iff (rst)
    port_done |=> !port_done);
endmodule

bind cfg_dma_cmdq cfg_dma_cmdq_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_checker (
  .clk(clk), .rst(rst), .q_full(q_full), .q_empty(q_empty),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
  .cmd_words(cmd_words), .cmd_last(cmd_last), .cmd_wb(cmd_wb),
  .dma_done(dma_done), .port_done(port_done)
);

// File: tb/cfg_dma_cmdq_test.sv
module cfg_dma_cmdq_test;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 27;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = '0;
  logic [ADDR_W-1:0] wr_data = '0;
  logic              cmd_ready = 1'b0;
  logic              xfer_done = 1'b0;
  logic              port_idle = 1'b0;
  logic              q_full, q_empty, cmd_err, cmd_valid, cmd_last, cmd_wb;
  logic              dma_done, port_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_words;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_dma_cmdq uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .q_full(q_full), .q_empty(q_empty), .cmd_err(cmd_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_words(cmd_words), .cmd_last(cmd_last), .cmd_wb(cmd_wb),
    .xfer_done(xfer_done), .port_idle(port_idle),
    .dma_done(dma_done), .port_done(port_done)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R2: four writes, the destination-length write queues
  task automatic push_cmd(logic [31:0] src, logic [31:0] dst, logic [31:0] len);
    reg_wr(2'd0, src);
    reg_wr(2'd1, dst);
    reg_wr(2'd2, len);
    reg_wr(2'd3, 32'd0);
  endtask

  task automatic accept(string req, logic [31:0] addr, logic [31:0] words,
                        logic last, logic wb);
    for (int i = 0; i < 50 && !cmd_valid; i++) @(negedge clk);
    check({req, " valid"}, cmd_valid, 1);
    check({req, " R3 addr"}, cmd_addr, addr);
    check({req, " R3 words"}, cmd_words, words);
    check({req, " R4 last"}, cmd_last, last);
    check({req, " R5 wb"}, cmd_wb, wb);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R9 nothing presented before xfer_done", cmd_valid, 0);
    end
  endtask

  task automatic finish_cmd();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R10 dma_done pulse", dma_done, 1);
    check("R11 no port_done with dma_done", port_done, 0);
    @(negedge clk);
    check("R10 dma_done one cycle", dma_done, 0);
  endtask

  task automatic t_reset();
    check("R1 empty", q_empty, 1);
    check("R1 full", q_full, 0);
    check("R1 valid", cmd_valid, 0);
    check("R1 dma_done", dma_done, 0);
    check("R1 port_done", port_done, 0);
    check("R1 err", cmd_err, 0);
  endtask

  task automatic t_plain();
    push_cmd(32'h1000_0000, 32'hFFFF_FFFF, 32'd16);
    check("R8 aligned no err", cmd_err, 0);
    accept("R2 plain", 32'h1000_0000, 16, 0, 0);
    port_idle = 1'b1;
    finish_cmd();
    repeat (3) begin
      @(negedge clk);
      check("R11 no port_done for non-last", port_done, 0);
    end
    port_idle = 1'b0;
  endtask

  task automatic t_writeback();
    push_cmd(32'h2000_0008, 32'h3000_0000, 32'd5);
    accept("R5 writeback", 32'h2000_0008, 5, 0, 1);
    finish_cmd();
  endtask

  task automatic t_last_wait();
    push_cmd(32'h4000_0011, 32'hFFFF_FFFF, 32'd7);
    accept("R4 last", 32'h4000_0010, 7, 1, 0);
    finish_cmd();
    repeat (3) begin
      @(negedge clk);
      check("R11 waits for port_idle", port_done, 0);
    end
    port_idle = 1'b1;
    @(negedge clk);
    port_idle = 1'b0;
    check("R11 port_done after drain", port_done, 1);
    @(negedge clk);
    check("R11 port_done one cycle", port_done, 0);
  endtask

  task automatic t_last_idle_high();
    push_cmd(32'h4800_0001, 32'hFFFF_FFFF, 32'd2);
    accept("R4 last idle-high", 32'h4800_0000, 2, 1, 0);
    port_idle = 1'b1;
    finish_cmd();
    check("R11 port_done next cycle", port_done, 1);
    port_idle = 1'b0;
  endtask

  task automatic t_misalign();
    push_cmd(32'h5000_0004, 32'hFFFF_FFFF, 32'd3);
    check("R8 err pulse", cmd_err, 1);
    check("R8 queue still empty", q_empty, 1);
    @(negedge clk);
    check("R8 err one cycle", cmd_err, 0);
    repeat (3) begin
      @(negedge clk);
      check("R8 nothing presented", cmd_valid, 0);
    end
  endtask

  task automatic t_full();
    push_cmd(32'h6000_0000, 32'hFFFF_FFFF, 32'd1);
    for (int k = 1; k <= 4; k++)
      push_cmd(32'h6000_0000 + 32'(k * 8), 32'hFFFF_FFFF, 32'(k + 1));
    check("R6 full after four", q_full, 1);
    check("R6 not empty", q_empty, 0);
    check("R9 stalled command held", cmd_addr, 32'h6000_0000);
    push_cmd(32'h6F00_0000, 32'hFFFF_FFFF, 32'd99);
    check("R7 overflow err", cmd_err, 1);
    check("R7 still full", q_full, 1);
    accept("R2 head", 32'h6000_0000, 1, 0, 0);
    check("R6 full kept while engine busy", q_full, 1);
    finish_cmd();
    for (int k = 1; k <= 4; k++) begin
      accept("R7 stored order", 32'h6000_0000 + 32'(k * 8), 32'(k + 1), 0, 0);
      check("R6 not full after pop", q_full, 0);
      finish_cmd();
    end
    check("R6 empty at end", q_empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_writeback();
    t_last_wait();
    t_last_idle_high();
    t_misalign();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule